// File: doc/BRIEF.md
# Mode-Configurable Distributed RAM

This block is a tiny memory built from one 64-bit storage array. A static mode input reshapes the array as 64 words of 1 bit, 32 words of 2 bits, or 32 words of 1 bit with two read ports. In the two-port shape, one port reads and writes and the other only reads. All three shapes share the same physical bits, so data written in one shape can be read back in another.

Writes land on the rising clock edge when write enable is high. A second static input sets the read style. When it is low, the output follows the address in the same cycle. When it is high, an output register adds one cycle of delay. The bits and the output register clear to zero under the active-low reset, which stands in for the clearing a device gets at power-up configuration. The block has no handshake: every input is sampled on every edge, and it never stalls the caller.

Top module: `cfg_lutram`

## Requirements
- R1: During and after reset, every one of the 64 storage bits reads as 0, and the read outputs are 0.
- R2: The mode input is coded 0 = 64x1, 1 = 32x2 and 2 = two-port 32x1. Code 3 is reserved: it writes nothing and drives all read outputs to 0.
- R3: In mode 0, the 6-bit address picks storage bit `addr`. A write stores `wdata[0]` there, the read returns that bit on `rdata[0]`, and `rdata[1]` is 0.
- R4: In mode 1, only `addr[4:0]` (a) is used and `addr[5]` is ignored. `wdata[0]`/`rdata[0]` go to bit a, and `wdata[1]`/`rdata[1]` go to bit a+32.
- R5: In mode 2, the write stores `wdata[0]` into bit `addr[4:0]` of the lower half, and `rdata[0]` reads that bit. `rdata_b` reads lower-half bit `raddr_b`. The upper half is untouched, and outside mode 2 `rdata_b` is 0.
- R6: Storage changes only on a rising edge where `we` is 1. With `we` at 0, a changing `wdata` leaves the contents unchanged.
- R7: With `rd_reg` at 0, the read outputs reflect the current address and contents within the same cycle, including a write made on the previous edge.
- R8: With `rd_reg` at 1, the read outputs show exactly what the asynchronous read gave one cycle earlier. This is one cycle of latency, so a write shows up one edge after it lands.
- R9: All modes share one array, so a bit written in one mode is read back at its mapped position in another mode. For example, bit 37 in mode 0 is `rdata[1]` at address 5 in mode 1.
- R10: In mode 2, when `raddr_b` equals the write address, `rdata_b` shows the newly written value right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the output register use its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears storage and output register |
| mode | input | 2 | Array shape select (0: 64x1, 1: 32x2, 2: two-port 32x1, 3: reserved) |
| rd_reg | input | 1 | 0: asynchronous read, 1: registered read |
| we | input | 1 | Write enable |
| addr | input | ADDR_W | Read/write address of the primary port |
| wdata | input | 2 | Write data; bit 1 is used only in mode 1 |
| raddr_b | input | ADDR_W-1 | Read address of the second port (mode 2) |
| rdata | output | 2 | Primary read data |
| rdata_b | output | 1 | Second-port read data |

## Verification
The bench builds the block with its default ADDR_W of 6, so the array is 64 bits. At that size, every location can be written and read back in each shape. That covers the full address sweep, the pairing of each lower bit with its partner 32 positions up, and the limit of the two-port shape to the lower half. The bench compares each read against its own model of the 64 bits, in both read styles. This exposes cross-mode aliasing and the one-cycle delay of the registered read, including a write landing while that register is in use.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
  typedef enum logic [1:0] {
    LM_WIDE = 2'd0,
    LM_PAIR = 2'd1,
    LM_DUAL = 2'd2,
    LM_NONE = 2'd3
  } lut_mode_e;
  localparam int unsigned LM_DATA_W = 2;
endpackage

// File: rtl/lutram_store.sv
module lutram_store
  import lutram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  lut_mode_e                mode,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [LM_DATA_W-1:0]     wdata,
  output logic [(1<<ADDR_W)-1:0]   bits
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned HALF  = DEPTH / 2;
  localparam int unsigned LW    = ADDR_W - 1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    localparam logic [ADDR_W-1:0] IDX   = ADDR_W'(i);
    localparam logic [LW-1:0]     LOW   = LW'(i % HALF);
    localparam bit                UPPER = (i >= HALF);
    logic hit, din;

    always_comb begin
      hit = 1'b0;
      din = wdata[0];
      unique case (mode)
        LM_WIDE: hit = (waddr == IDX);
        LM_PAIR: begin
          hit = (waddr[LW-1:0] == LOW);
          din = UPPER ? wdata[1] : wdata[0];
        end
        LM_DUAL: hit = !UPPER && (waddr[LW-1:0] == LOW);
        default: hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          bits[i] <= 1'b0;
      else if (we && hit)  bits[i] <= din;
    end
  end
endmodule

// File: rtl/lutram_rdmux.sv
module lutram_rdmux
  import lutram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [(1<<ADDR_W)-1:0] bits,
  input  lut_mode_e              mode,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [ADDR_W-2:0]      raddr_b,
  output logic [LM_DATA_W-1:0]   rd_a,
  output logic                   rd_b
);
  localparam int unsigned LW = ADDR_W - 1;
  logic [LW-1:0] lo;

  always_comb begin
    lo   = addr[LW-1:0];
    rd_a = '0;
    rd_b = 1'b0;
    unique case (mode)
      LM_WIDE: rd_a[0] = bits[addr];
      LM_PAIR: rd_a = {bits[{1'b1, lo}], bits[{1'b0, lo}]};
      LM_DUAL: begin
        rd_a[0] = bits[{1'b0, lo}];
        rd_b    = bits[{1'b0, raddr_b}];
      end
      default: begin
        rd_a = '0;
        rd_b = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lutram_outreg.sv
module lutram_outreg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         use_reg,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_ff
    logic held;
    always_ff @(posedge clk) begin
      if (!rst_n) held <= 1'b0;
      else        held <= d[i];
    end
    assign q[i] = use_reg ? held : d[i];
  end
endmodule

// File: rtl/cfg_lutram.sv
module cfg_lutram
  import lutram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              rd_reg,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wdata,
  input  logic [ADDR_W-2:0] raddr_b,
  output logic [1:0]        rdata,
  output logic              rdata_b
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned OUT_W = LM_DATA_W + 1;

  lut_mode_e            mode_e;
  logic [DEPTH-1:0]     bits;
  logic [LM_DATA_W-1:0] rd_a;
  logic                 rd_b;
  logic [OUT_W-1:0]     out_q;

  assign mode_e = lut_mode_e'(mode);

  lutram_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .mode(mode_e),
    .waddr(addr), .wdata(wdata), .bits(bits)
  );

  lutram_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .bits(bits), .mode(mode_e), .addr(addr), .raddr_b(raddr_b),
    .rd_a(rd_a), .rd_b(rd_b)
  );

  lutram_outreg #(.W(OUT_W)) u_outreg (
    .clk(clk), .rst_n(rst_n), .use_reg(rd_reg),
    .d({rd_b, rd_a}), .q(out_q)
  );

  assign rdata   = out_q[LM_DATA_W-1:0];
  assign rdata_b = out_q[OUT_W-1];
endmodule

// File: rtl/cfg_lutram_chk.sv
module cfg_lutram_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              rd_reg,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        wdata,
  input logic [ADDR_W-2:0] raddr_b,
  input logic [1:0]        rdata,
  input logic              rdata_b,
  input logic [1:0]        rd_a,
  input logic              rd_b
);
  AST_WIDE_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode == 2'd0 && !rd_reg) |=>
      (!$stable(addr) || !$stable(mode) || rd_reg || rdata[0] == $past(wdata[0]))); // R3

  AST_UPPER_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_reg && mode != 2'd1) |-> (rdata[1] == 1'b0)); // R3

  AST_PORTB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_reg && mode != 2'd2) |-> (rdata_b == 1'b0)); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !rd_reg) |=>
      (!$stable(addr) || !$stable(mode) || !$stable(raddr_b) || rd_reg ||
       ($stable(rdata) && $stable(rdata_b)))); // R6

  AST_REG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reg |=> (!rd_reg || (rdata == $past(rd_a) && rdata_b == $past(rd_b)))); // R8

  AST_DUAL_B_SEES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode == 2'd2 && !rd_reg && raddr_b == addr[ADDR_W-2:0]) |=>
      (!$stable(addr) || !$stable(raddr_b) || !$stable(mode) || rd_reg ||
       rdata_b == $past(wdata[0]))); // R10
endmodule

bind cfg_lutram cfg_lutram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_reg(rd_reg), .we(we),
  .addr(addr), .wdata(wdata), .raddr_b(raddr_b), .rdata(rdata),
  .rdata_b(rdata_b), .rd_a(rd_a), .rd_b(rd_b)
);

// File: tb/cfg_lutram_test.sv
module cfg_lutram_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic rd_reg = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] wdata = '0;
  logic [4:0] raddr_b = '0;
  logic [1:0] rdata;
  logic rdata_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic mdl [64];

  always #(CLK_P/2) clk = ~clk;

  cfg_lutram #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_reg(rd_reg), .we(we),
    .addr(addr), .wdata(wdata), .raddr_b(raddr_b),
    .rdata(rdata), .rdata_b(rdata_b)
  );

  function automatic logic [2:0] expect_out(logic [1:0] m, logic [5:0] a, logic [4:0] b);
    case (m)
      2'd0:    return {2'b00, mdl[a]};
      2'd1:    return {1'b0, mdl[{1'b1, a[4:0]}], mdl[{1'b0, a[4:0]}]};
      2'd2:    return {mdl[{1'b0, b}], 1'b0, mdl[{1'b0, a[4:0]}]};
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(string req, logic [2:0] exp);
    n_chk++;
    if ({rdata_b, rdata} !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d addr=%0d raddr_b=%0d actual=%b expected=%b",
               req, mode, addr, raddr_b, {rdata_b, rdata}, exp);
    end
  endtask

  task automatic do_write(logic [1:0] m, logic [5:0] a, logic [1:0] d);
    mode = m; addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    case (m)
      2'd0: mdl[a] = d[0];
      2'd1: begin mdl[{1'b0, a[4:0]}] = d[0]; mdl[{1'b1, a[4:0]}] = d[1]; end
      2'd2: mdl[{1'b0, a[4:0]}] = d[0];
      default: ;
    endcase
  endtask

  task automatic read_async(string req, logic [1:0] m, logic [5:0] a, logic [4:0] b);
    mode = m; addr = a; raddr_b = b; #1;
    check(req, expect_out(m, a, b));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 3'b000);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) mdl[i] = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < 64; i++) read_async("R1", 2'd0, 6'(i), 5'd0);
  endtask

  task automatic t_wide;
    for (int i = 0; i < 64; i++) do_write(2'd0, 6'(i), {1'b1, ^(6'(i * 5 + 1))});
    for (int i = 0; i < 64; i++) read_async("R3 R7", 2'd0, 6'(i), 5'd0);
  endtask

  task automatic t_pair;
    do_write(2'd1, 6'd37, 2'b10);
    do_write(2'd1, 6'd9, 2'b01);
    do_write(2'd1, 6'd63, 2'b11);
    read_async("R4 addr5 ignored", 2'd1, 6'd5, 5'd0);
    read_async("R4", 2'd1, 6'd41, 5'd0);
    read_async("R4", 2'd1, 6'd31, 5'd0);
    read_async("R9 upper bit", 2'd0, 6'd37, 5'd0);
    read_async("R9 lower bit", 2'd0, 6'd5, 5'd0);
    read_async("R9 pair of 9", 2'd0, 6'd41, 5'd0);
  endtask

  task automatic t_dual;
    logic keep;
    keep = mdl[44];
    do_write(2'd2, 6'd44, 2'b11);
    do_write(2'd2, 6'd3, 2'b00);
    for (int b = 0; b < 32; b += 3) read_async("R5", 2'd2, 6'd12, 5'(b));
    mode = 2'd0; addr = 6'd44; #1;
    n_chk++;
    if (rdata[0] !== keep) begin
      n_bad++;
      $display("FAIL R5 upper half touched actual=%b expected=%b", rdata[0], keep);
    end
    mode = 2'd2; addr = 6'd20; raddr_b = 5'd20; #1;
    do_write(2'd2, 6'd20, {1'b0, ~mdl[20]});
    check("R10 port B after write", expect_out(2'd2, 6'd20, 5'd20));
    read_async("R5 port B idle in mode 1", 2'd1, 6'd20, 5'd20);
  endtask

  task automatic t_nowe;
    mode = 2'd1; addr = 6'd7;
    for (int k = 0; k < 4; k++) begin
      wdata = 2'(k); @(posedge clk); #1;
      check("R6", expect_out(2'd1, 6'd7, 5'd0));
    end
    for (int i = 0; i < 64; i += 5) read_async("R6 sweep", 2'd0, 6'(i), 5'd0);
  endtask

  task automatic t_reserved;
    do_write(2'd3, 6'd50, {1'b1, ~mdl[50]});
    do_write(2'd3, 6'd18, {~mdl[50], ~mdl[18]});
    read_async("R2 reserved outputs", 2'd3, 6'd50, 5'd18);
    read_async("R2 no write", 2'd0, 6'd50, 5'd0);
    read_async("R2 no write", 2'd1, 6'd18, 5'd0);
  endtask

  task automatic t_registered;
    logic [2:0] e_old;
    logic [2:0] e_new;
    rd_reg = 1'b1;
    mode = 2'd0; addr = 6'd1; raddr_b = 5'd0;
    @(posedge clk); #1;
    check("R8 captured", expect_out(2'd0, 6'd1, 5'd0));
    e_old = expect_out(2'd0, 6'd1, 5'd0);
    addr = 6'd2; #2;
    check("R8 held in cycle", e_old);
    @(posedge clk); #1;
    check("R8 one cycle", expect_out(2'd0, 6'd2, 5'd0));
    e_old = expect_out(2'd0, 6'd2, 5'd0);
    do_write(2'd0, 6'd2, {1'b0, ~mdl[2]});
    check("R8 write not yet seen", e_old);
    @(posedge clk); #1;
    check("R8 write seen", expect_out(2'd0, 6'd2, 5'd0));
    mode = 2'd2; addr = 6'd4; raddr_b = 5'd9;
    @(posedge clk); #1;
    e_new = expect_out(2'd2, 6'd4, 5'd9);
    check("R8 dual registered", e_new);
    rd_reg = 1'b0; #1;
    check("R7 back to async", e_new);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wide();
    t_pair();
    t_dual();
    t_nowe();
    t_reserved();
    t_registered();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule